// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is a bus-attached SPI master with nine 32-bit registers in a 1 KB window. Software selects clock polarity, clock phase, a power-of-two clock divider and an enable bit. It then moves one byte at a time through the data register. Writing the data register sends the written byte. Reading the data register first sends the byte the register currently holds, then returns what came back on MISO. A read therefore holds the bus until its own exchange has finished.

The receive-ready flag is driven straight onto an interrupt line. The check-sum and audio registers have no function; they only hold their defined reset values. Bus accesses use a request held until a one-cycle ready pulse, which makes a data-register read stall naturally.

Top module: `spim_ctrl`

## Requirements
- R1: After reset the registers read as follows: control A (0x00) = 0, control B (0x04) = 0, status (0x08) = 0x0000000A, data (0x0C) = 0x0000000C, polynomial (0x10) = 0x00000007, receive check (0x14) = 0, transmit check (0x18) = 0, audio setup (0x1C) = 0, audio prescale (0x20) = 0x00000002. Also, `irq` is low, `spi_cs_n` is high and `spi_sclk` is low.
- R2: When the enable bit (control A bit 6) is set, a write to the data register sends bits 7:0 MSB first with `spi_cs_n` low. When the exchange finishes, the data register holds the received byte zero-extended and status bit 0 (receive-ready) is 1.
- R3: When enabled, a data-register read withholds `bus_ready` until an exchange of the data register's current byte completes. It then returns the received byte and leaves receive-ready at 0.
- R4: Control A and control B read back exactly the last 32-bit value written. Bits of control B have no effect on the exchange.
- R5: Writes to status are ignored. Status bit 1 is 1 and bit 7 is 0 when no exchange is in progress. Bit 7 is 1 and bit 1 is 0 during an exchange. Bit 3 always reads 1.
- R6: Writes to offsets 0x10, 0x14, 0x18, 0x1C and 0x20 are discarded, and these registers keep reading their R1 values.
- R7: Offsets that match no register read as zero, and writes to them change nothing.
- R8: Control A bit 1 (CPOL) is the idle level of `spi_sclk`. With control A bit 0 (CPHA) = 0, data is sampled on the first edge of each bit; with CPHA = 1, it is sampled on the second edge. Control A bits 5:3 = n gives each `spi_sclk` half period 2^n clock cycles.
- R9: With the enable bit clear, a data write only stores the value: `spi_cs_n` stays high and receive-ready is unchanged. A data read returns the stored value and clears receive-ready.
- R10: `irq` equals status bit 0.
- R11: A data-register access issued while an exchange runs is held off until that exchange completes. Other registers stay accessible during an exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, held until `bus_ready` |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| bus_ready | output | 1 | One-cycle completion pulse |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |
| irq | output | 1 | Receive-ready interrupt |

## Verification
The assertions assume the bus master keeps `bus_req`, `bus_wr`, `bus_addr` and `bus_wdata` steady until it sees `bus_ready`, and drops `bus_req` before the following edge. The bench's single access task does exactly this, driving on the falling edge and releasing right after the ready pulse. The assertions also assume MISO changes only on the serial-clock edge where the selected mode does not sample. The bench's slave model drives MISO only on those edges, for the CPOL/CPHA it is told the controller uses.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;

    localparam int ADDR_W = 10;
    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int DIV_W  = 3;

    localparam logic [ADDR_W-1:0] OFS_CTLA  = 10'h000;
    localparam logic [ADDR_W-1:0] OFS_CTLB  = 10'h004;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 10'h008;
    localparam logic [ADDR_W-1:0] OFS_DATA  = 10'h00C;
    localparam logic [ADDR_W-1:0] OFS_POLY  = 10'h010;
    localparam logic [ADDR_W-1:0] OFS_RXCHK = 10'h014;
    localparam logic [ADDR_W-1:0] OFS_TXCHK = 10'h018;
    localparam logic [ADDR_W-1:0] OFS_ACFG  = 10'h01C;
    localparam logic [ADDR_W-1:0] OFS_APRE  = 10'h020;

    localparam logic [WORD_W-1:0] INIT_DATA  = 32'h0000_000C;
    localparam logic [WORD_W-1:0] INIT_POLY  = 32'h0000_0007;
    localparam logic [WORD_W-1:0] INIT_CHK   = 32'h0000_0000;
    localparam logic [WORD_W-1:0] INIT_ACFG  = 32'h0000_0000;
    localparam logic [WORD_W-1:0] INIT_APRE  = 32'h0000_0002;
    localparam logic [WORD_W-1:0] STAT_FIXED = 32'h0000_0008;

    localparam int CA_CPHA = 0;
    localparam int CA_CPOL = 1;
    localparam int CA_DIV  = 3;
    localparam int CA_EN   = 6;

    localparam int ST_RDY  = 0;
    localparam int ST_IDLE = 1;
    localparam int ST_BUSY = 7;

    typedef enum logic [1:0] {SH_IDLE, SH_RUN, SH_TAIL} shf_state_e;
    typedef enum logic {BUS_IDLE, BUS_RDWAIT} bus_state_e;

    typedef struct packed {
        logic             en;
        logic [DIV_W-1:0] div;
        logic             cpol;
        logic             cpha;
    } spi_mode_t;

    function automatic spi_mode_t decode_mode(input logic [WORD_W-1:0] ctl);
        spi_mode_t m;
        m.en   = ctl[CA_EN];
        m.div  = ctl[CA_DIV +: DIV_W];
        m.cpol = ctl[CA_CPOL];
        m.cpha = ctl[CA_CPHA];
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(input logic live, input logic rdy);
        logic [WORD_W-1:0] s;
        s          = STAT_FIXED;
        s[ST_RDY]  = rdy;
        s[ST_IDLE] = ~live;
        s[ST_BUSY] = live;
        return s;
    endfunction

endpackage

// File: rtl/spim_clkdiv.sv
`timescale 1ns/1ps
module spim_clkdiv #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CNT_W = (1 << DIV_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic [CNT_W:0]   span;

    always_comb begin
        span  = (CNT_W+1)'(1) << div;
        limit = span[CNT_W-1:0] - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !run)        cnt <= '0;
        else if (cnt == limit)  cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == limit);

    // R8: the count never passes the limit of the selected divider
    assert_cnt_in_range_R8: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= limit));

endmodule

// File: rtl/spim_shifter.sv
`timescale 1ns/1ps
module spim_shifter
    import spim_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int DIV_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx,
    input  spi_mode_t         mode,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] rx
);
    localparam int EDGES = 2 * BYTE_W;
    localparam int EW    = $clog2(EDGES);
    localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

    shf_state_e        state;
    logic [BYTE_W-1:0] shreg, rxreg;
    logic [EW-1:0]     edge_idx;
    logic              sclk_q, cs_q, done_q, lat_cpol, lat_cpha, tick, lead;

    spim_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (state == SH_RUN),
        .div  (mode.div),
        .tick (tick)
    );

    assign lead = ~edge_idx[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SH_IDLE;
            shreg    <= '0;
            rxreg    <= '0;
            edge_idx <= '0;
            sclk_q   <= 1'b0;
            cs_q     <= 1'b1;
            done_q   <= 1'b0;
            lat_cpol <= 1'b0;
            lat_cpha <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                SH_IDLE: if (start) begin
                    state    <= SH_RUN;
                    shreg    <= tx;
                    rxreg    <= '0;
                    edge_idx <= '0;
                    sclk_q   <= mode.cpol;
                    lat_cpol <= mode.cpol;
                    lat_cpha <= mode.cpha;
                    cs_q     <= 1'b0;
                end
                SH_RUN: if (tick) begin
                    sclk_q   <= ~sclk_q;
                    edge_idx <= edge_idx + 1'b1;
                    if (lead != lat_cpha)
                        rxreg <= {rxreg[BYTE_W-2:0], miso};
                    else if (!(lat_cpha && edge_idx == '0))
                        shreg <= shreg << 1;
                    if (edge_idx == LAST_EDGE)
                        state <= SH_TAIL;
                end
                SH_TAIL: begin
                    cs_q   <= 1'b1;
                    done_q <= 1'b1;
                    state  <= SH_IDLE;
                end
                default: state <= SH_IDLE;
            endcase
        end
    end

    assign sclk = (state == SH_IDLE) ? mode.cpol : sclk_q;
    assign mosi = shreg[BYTE_W-1];
    assign cs_n = cs_q;
    assign busy = (state != SH_IDLE);
    assign done = done_q;
    assign rx   = rxreg;

    // R2: completion is a single-cycle event
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    // R2: select is released whenever no exchange runs
    assert_cs_released_R2: assert property (@(posedge clk) disable iff (rst)
        (state == SH_IDLE) |-> cs_q);
    // R8: the clock is back at its idle level before select rises
    assert_sclk_rest_R8: assert property (@(posedge clk) disable iff (rst)
        (state == SH_TAIL) |-> (sclk_q == lat_cpol));

endmodule

// File: rtl/spim_ctrl.sv
`timescale 1ns/1ps
module spim_ctrl
    import spim_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_req,
    input  logic        bus_wr,
    input  logic [9:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_ready,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic        spi_cs_n,
    output logic        irq
);
    logic [WORD_W-1:0] ctla, ctlb, data_q, rdata_q, rd_mux;
    logic              rxne, ready_q;
    bus_state_e        bst;
    spi_mode_t         mode;
    logic              shf_busy, shf_done, xfer_live, hit_data, acc, start;
    logic [BYTE_W-1:0] shf_rx, tx_byte;

    assign mode      = decode_mode(ctla);
    assign xfer_live = shf_busy | shf_done;
    assign hit_data  = (bus_addr == OFS_DATA);
    assign acc       = bus_req && !ready_q && (bst == BUS_IDLE) && !(hit_data && xfer_live);
    assign start     = acc && hit_data && mode.en;
    assign tx_byte   = bus_wr ? bus_wdata[BYTE_W-1:0] : data_q[BYTE_W-1:0];

    spim_shifter #(.BYTE_W(BYTE_W), .DIV_W(DIV_W)) u_shf (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .tx    (tx_byte),
        .mode  (mode),
        .miso  (spi_miso),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .cs_n  (spi_cs_n),
        .busy  (shf_busy),
        .done  (shf_done),
        .rx    (shf_rx)
    );

    always_comb begin
        case (bus_addr)
            OFS_CTLA:  rd_mux = ctla;
            OFS_CTLB:  rd_mux = ctlb;
            OFS_STAT:  rd_mux = pack_status(xfer_live, rxne);
            OFS_DATA:  rd_mux = data_q;
            OFS_POLY:  rd_mux = INIT_POLY;
            OFS_RXCHK: rd_mux = INIT_CHK;
            OFS_TXCHK: rd_mux = INIT_CHK;
            OFS_ACFG:  rd_mux = INIT_ACFG;
            OFS_APRE:  rd_mux = INIT_APRE;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctla    <= '0;
            ctlb    <= '0;
            data_q  <= INIT_DATA;
            rxne    <= 1'b0;
            rdata_q <= '0;
            ready_q <= 1'b0;
            bst     <= BUS_IDLE;
        end else begin
            ready_q <= 1'b0;
            if (shf_done) begin
                data_q <= WORD_W'(shf_rx);
                if (bst == BUS_RDWAIT) begin
                    rxne    <= 1'b0;
                    rdata_q <= WORD_W'(shf_rx);
                    ready_q <= 1'b1;
                    bst     <= BUS_IDLE;
                end else begin
                    rxne <= 1'b1;
                end
            end
            if (acc) begin
                if (bus_wr) begin
                    case (bus_addr)
                        OFS_CTLA: ctla   <= bus_wdata;
                        OFS_CTLB: ctlb   <= bus_wdata;
                        OFS_DATA: data_q <= bus_wdata;
                        default:  ;
                    endcase
                    ready_q <= 1'b1;
                end else if (hit_data && mode.en) begin
                    bst <= BUS_RDWAIT;
                end else begin
                    rdata_q <= rd_mux;
                    ready_q <= 1'b1;
                    if (hit_data) rxne <= 1'b0;
                end
            end
        end
    end

    assign bus_rdata = rdata_q;
    assign bus_ready = ready_q;
    assign irq       = rxne;

    // R3: completion is signalled for one cycle only
    assert_ready_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        bus_ready |=> !bus_ready);
    // R3: a waiting read completes with its exchange and leaves receive-ready clear
    assert_read_finishes_R3: assert property (@(posedge clk) disable iff (rst)
        (bst == BUS_RDWAIT && shf_done) |=> (bus_ready && !rxne));
    // R2: receive-ready only rises after an exchange has finished
    assert_rdy_from_xfer_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(rxne) |-> $past(shf_done));
    // R11: a data access during an exchange is not completed
    assert_data_held_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_req && hit_data && shf_busy && bst == BUS_IDLE && !ready_q) |=> !bus_ready);

endmodule

// File: tb/spim_ctrl_test.sv
`timescale 1ns/1ps
module spim_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0, bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready, spi_sclk, spi_mosi, spi_cs_n, irq;
    logic        s_miso = 1'b0;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    int cs_falls = 0;

    always #2.5 clk = ~clk;

    spim_ctrl uut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(s_miso), .spi_cs_n(spi_cs_n), .irq(irq)
    );

    // serial slave model
    logic       tb_cpol = 1'b0, tb_cpha = 1'b0;
    logic [7:0] slv_reply = '0, slv_got = '0, s_tx = '0, s_rx = '0;
    real        last_t = 0.0, edge_gap = 0.0;

    always @(negedge spi_cs_n) begin
        cs_falls = cs_falls + 1;
        s_tx = slv_reply;
        s_rx = '0;
        last_t = $realtime;
        if (!tb_cpha) s_miso = s_tx[7];
    end

    always @(posedge spi_cs_n) slv_got = s_rx;

    always @(spi_sclk) begin
        if (!spi_cs_n) begin
            edge_gap = $realtime - last_t;
            last_t = $realtime;
            if ((spi_sclk != tb_cpol) != tb_cpha) begin
                s_rx = {s_rx[6:0], spi_mosi};
            end else if (tb_cpha) begin
                s_miso = s_tx[7];
                s_tx = s_tx << 1;
            end else begin
                s_tx = s_tx << 1;
                s_miso = s_tx[7];
            end
        end
    end

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors = vectors + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_xact(input logic wr, input logic [9:0] a, input logic [31:0] wd,
                            output logic [31:0] rd);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        do begin
            @(posedge clk); #1;
        end while (!bus_ready);
        rd = bus_rdata;
        bus_req = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr32(input logic [9:0] a, input logic [31:0] d);
        logic [31:0] dummy;
        bus_xact(1'b1, a, d, dummy);
    endtask

    task automatic rd32(input logic [9:0] a, output logic [31:0] d);
        bus_xact(1'b0, a, '0, d);
    endtask

    task automatic wait_idle();
        logic [31:0] st;
        for (int i = 0; i < 5000; i++) begin
            rd32(10'h008, st);
            if (!st[7]) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd32(10'h000, v); chk("R1 ctla", v, 32'h0);
        rd32(10'h004, v); chk("R1 ctlb", v, 32'h0);
        rd32(10'h008, v); chk("R1 status", v, 32'h0A);
        rd32(10'h00C, v); chk("R1 data", v, 32'h0C);
        rd32(10'h010, v); chk("R1 poly", v, 32'h07);
        rd32(10'h014, v); chk("R1 rxchk", v, 32'h0);
        rd32(10'h018, v); chk("R1 txchk", v, 32'h0);
        rd32(10'h01C, v); chk("R1 acfg", v, 32'h0);
        rd32(10'h020, v); chk("R1 apre", v, 32'h02);
        chk("R1 pins irq/cs/sclk", {29'h0, irq, spi_cs_n, spi_sclk}, 32'h2);
    endtask

    task automatic t_ctl();
        logic [31:0] v;
        wr32(10'h004, 32'hDEAD_BEEF);
        rd32(10'h004, v); chk("R4 ctlb readback", v, 32'hDEAD_BEEF);
        wr32(10'h000, 32'hA5A5_A5B5);
        rd32(10'h000, v); chk("R4 ctla readback", v, 32'hA5A5_A5B5);
        wr32(10'h000, 32'h0);
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        wr32(10'h008, 32'hFFFF_FFFF); rd32(10'h008, v); chk("R5 status write ignored", v, 32'h0A);
        wr32(10'h010, 32'hFFFF_FFFF); rd32(10'h010, v); chk("R6 poly", v, 32'h07);
        wr32(10'h014, 32'hFFFF_FFFF); rd32(10'h014, v); chk("R6 rxchk", v, 32'h0);
        wr32(10'h018, 32'hFFFF_FFFF); rd32(10'h018, v); chk("R6 txchk", v, 32'h0);
        wr32(10'h01C, 32'hFFFF_FFFF); rd32(10'h01C, v); chk("R6 acfg", v, 32'h0);
        wr32(10'h020, 32'hFFFF_FFFF); rd32(10'h020, v); chk("R6 apre", v, 32'h02);
        wr32(10'h024, 32'hFFFF_FFFF); rd32(10'h024, v); chk("R7 unmapped 0x24", v, 32'h0);
        wr32(10'h3FC, 32'h1234_5678); rd32(10'h3FC, v); chk("R7 unmapped 0x3FC", v, 32'h0);
        rd32(10'h000, v); chk("R7 ctla untouched", v, 32'h0);
        rd32(10'h00C, v); chk("R7 data untouched", v, 32'h0C);
    endtask

    task automatic t_xfer(input logic cpol, input logic cpha, input int div,
                          input logic [7:0] tx, input logic [7:0] r1, input logic [7:0] r2);
        logic [31:0] v;
        tb_cpol = cpol; tb_cpha = cpha;
        wr32(10'h000, 32'h40 | (div << 3) | (cpol << 1) | cpha);
        chk("R8 sclk idle level", {31'h0, spi_sclk}, {31'h0, cpol});
        slv_reply = r1;
        wr32(10'h00C, {24'hFFFFFF, tx});
        wait_idle();
        chk("R2 slave received tx", {24'h0, slv_got}, {24'h0, tx});
        rd32(10'h008, v); chk("R5 status after write exchange", v, 32'h0B);
        chk("R10 irq follows ready", {31'h0, irq}, 32'h1);
        vectors = vectors + 1;
        if (edge_gap < (2.0 ** div) * 5.0 - 0.1 || edge_gap > (2.0 ** div) * 5.0 + 0.1) begin
            fails = fails + 1;
            $display("FAIL R8 half period: got %f expected %f", edge_gap, (2.0 ** div) * 5.0);
        end
        slv_reply = r2;
        rd32(10'h00C, v); chk("R3 read returns new byte", v, {24'h0, r2});
        chk("R3 read sent stored byte", {24'h0, slv_got}, {24'h0, r1});
        chk("R3 ready cleared, irq low", {31'h0, irq}, 32'h0);
        rd32(10'h008, v); chk("R3 status after read", v, 32'h0A);
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        int falls;
        tb_cpol = 1'b0; tb_cpha = 1'b0;
        wr32(10'h000, 32'h40);
        slv_reply = 8'h22;
        wr32(10'h00C, 32'h11);
        wait_idle();
        wr32(10'h000, 32'h0);
        falls = cs_falls;
        wr32(10'h00C, 32'h0000_0155);
        repeat (40) @(posedge clk);
        #1;
        chk("R9 no select when disabled", cs_falls, falls);
        chk("R9 ready unchanged by write", {31'h0, irq}, 32'h1);
        rd32(10'h00C, v); chk("R9 read returns stored", v, 32'h0000_0155);
        chk("R9 read clears ready", {31'h0, irq}, 32'h0);
        chk("R9 no select on read", cs_falls, falls);
    endtask

    task automatic t_overlap();
        logic [31:0] v;
        tb_cpol = 1'b1; tb_cpha = 1'b1;
        wr32(10'h000, 32'h40 | (7 << 3) | 2 | 1);
        slv_reply = 8'h9C;
        wr32(10'h00C, 32'h66);
        rd32(10'h008, v); chk("R11 status reachable while busy", v, 32'h88);
        rd32(10'h004, v); chk("R11 ctlb reachable while busy", v, 32'hDEAD_BEEF);
        slv_reply = 8'hE7;
        rd32(10'h00C, v); chk("R11 held read returns second reply", v, 32'hE7);
        chk("R11 second exchange sent first reply", {24'h0, slv_got}, 32'h9C);
        chk("R11 ready clear after read", {31'h0, irq}, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_ctl();
        t_ignored();
        t_xfer(1'b0, 1'b0, 0, 8'hA5, 8'h3C, 8'h81);
        t_xfer(1'b0, 1'b1, 1, 8'h5A, 8'hC3, 8'h7E);
        t_xfer(1'b1, 1'b0, 2, 8'h01, 8'h80, 8'hF0);
        t_xfer(1'b1, 1'b1, 3, 8'hFE, 8'h0F, 8'h69);
        t_disabled();
        t_overlap();
        finish_run();
    end

endmodule